// File: doc/BRIEF.md
# Self-Sizing Displacement Field Decoder

This block sits behind an instruction byte stream and turns a variable-length displacement into a 32-bit signed value. It takes one byte per cycle over a valid/ready handshake, with the most significant byte first. The first byte carries its own length in its top bits, and the remaining bits of the field are a two's complement number. Once the last byte of a field has been taken, the block presents the sign-extended value and the number of bytes that field used, together with a one-cycle done strobe.

A start pulse arms the decoder and selects one of three modes. Single mode decodes one displacement. Pair mode decodes two complete displacements back to back, for addressing modes that need both. Immediate mode skips length decoding: it collects 1, 2 or 4 bytes as given by a size code taken at start, which comes from the opcode decoder elsewhere. One reserved first byte of the long form is reported as an illegal encoding in place of a value.

Top module: `disp_field_decoder`

## Requirements
- R1: After reset, byte_ready_o, done_o and illegal_o are low. The block stays idle until a start_i pulse, and byte_ready_o is high from the cycle after that pulse.
- R2: A first byte with bit 7 equal to 0 is a 1-byte field whose value is bits 6:0. done_o comes with count_o = 1.
- R3: A first byte with bits 7:6 equal to 10 is a 2-byte field. Its 14-bit value is the first byte's bits 5:0 followed by the second byte. done_o comes with count_o = 2.
- R4: A first byte with bits 7:6 equal to 11 is a 4-byte field. Its 30-bit value is the first byte's bits 5:0 followed by the next three bytes in arrival order. done_o comes with count_o = 4.
- R5: value_o is the field's value sign-extended from its top value bit (bit 6, 13 or 29) to 32 bits.
- R6: done_o is high for exactly the cycle after the field's last byte is accepted, and never earlier. In single mode byte_ready_o is low in that cycle and stays low until the next start_i.
- R7: Start with pair_i = 1 (and imm_i = 0) decodes two fields in sequence. byte_ready_o stays high between them. second_o is 0 on the first done and 1 on the second, and the block returns to idle after the second.
- R8: Start with imm_i = 1 collects an immediate whose length comes from imm_size_i (00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes). The bytes are not length-decoded. The whole 8, 16 or 32 bits are sign-extended from their top bit. pair_i is ignored, and first byte 0xE0 is plain data.
- R9: In single or pair mode, a first byte of 0xE0 raises illegal_o for one cycle without done_o and returns the block to idle, which abandons any pending second field.
- R10: start_i while a field is being collected has no effect on mode, length or value. Bytes offered while idle are not taken and produce no done_o.
- R11: A byte is taken only in a cycle where byte_valid_i and byte_ready_o are both high. Cycles with byte_valid_i low between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arms the decoder when idle |
| pair_i | input | 1 | With start_i: decode two displacements |
| imm_i | input | 1 | With start_i: immediate mode, length from imm_size_i |
| imm_size_i | input | 2 | Immediate size code, sampled with start_i |
| byte_i | input | 8 | Stream byte, most significant first |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_ready_o | output | 1 | Decoder is collecting bytes |
| value_o | output | 32 | Sign-extended result, held until the next done |
| count_o | output | 3 | Bytes used by the completed field |
| done_o | output | 1 | One-cycle completion strobe |
| second_o | output | 1 | The completed field is the second of a pair |
| illegal_o | output | 1 | One-cycle reserved-encoding flag |

## Verification
In pair mode, the done strobe for the first displacement is high in the same cycle that the first byte of the second displacement is accepted. That cycle must report the first result while the collector restarts its count and length for the new field. The bench provokes this by offering the next byte at the first falling edge after each completion. It then checks that the first value and second_o = 0 are visible in that cycle, and that the second field, which may be a single byte producing two done strobes in a row, decodes to its own value with second_o = 1.

// File: rtl/disp_dec_pkg.sv
package disp_dec_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned MAX_BYTES = 4;
   localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);

   typedef enum logic [1:0] {
      LEN_1B = 2'd0,
      LEN_2B = 2'd1,
      LEN_4B = 2'd2
   } len_e;

   typedef enum logic {
      ST_IDLE    = 1'b0,
      ST_COLLECT = 1'b1
   } state_e;

   typedef struct packed {
      logic pair;
      logic imm;
      len_e imm_len;
   } mode_t;

   function automatic logic [CNT_W-1:0] len_bytes(input len_e l);
      case (l)
         LEN_1B:  len_bytes = CNT_W'(1);
         LEN_2B:  len_bytes = CNT_W'(2);
         default: len_bytes = CNT_W'(4);
      endcase
   endfunction

   function automatic len_e size_code_to_len(input logic [1:0] code);
      case (code)
         2'b00:   size_code_to_len = LEN_1B;
         2'b01:   size_code_to_len = LEN_2B;
         default: size_code_to_len = LEN_4B;
      endcase
   endfunction
endpackage

// File: rtl/disp_len_detect.sv
module disp_len_detect
   import disp_dec_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RESERVED_PAT = 8'hE0
) (
   input  logic [BYTE_W-1:0] lead_byte_i,
   input  logic              imm_i,
   input  len_e              imm_len_i,
   output len_e              len_o,
   output logic              reserved_o
);
   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("disp_len_detect: length prefix layout needs 8-bit bytes");
   end

   // The leading bits select the length; immediate mode takes the external size.
   always_comb begin
      reserved_o = 1'b0;
      if (imm_i) begin
         len_o = imm_len_i;
      end else begin
         if (!lead_byte_i[BYTE_W-1])      len_o = LEN_1B;
         else if (!lead_byte_i[BYTE_W-2]) len_o = LEN_2B;
         else                             len_o = LEN_4B;
         reserved_o = (lead_byte_i == RESERVED_PAT);
      end
   end
endmodule

// File: rtl/disp_byte_collector.sv
module disp_byte_collector
   import disp_dec_pkg::*;
#(
   parameter int unsigned ACC_W = BYTE_W * MAX_BYTES
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              abort_i,
   input  logic              take_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  len_e              len_first_i,
   output logic              first_o,
   output len_e              len_o,
   output logic              last_o,
   output logic [CNT_W-1:0]  used_o,
   output logic [ACC_W-1:0]  acc_next_o
);
   if (ACC_W != BYTE_W * MAX_BYTES) begin : g_bad_acc_w
      $error("disp_byte_collector: accumulator must hold the longest field");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   len_e             len_q;
   logic [ACC_W-1:0] acc_q;

   assign first_o = (cnt_q == '0);
   assign len_o   = first_o ? len_first_i : len_q;
   assign cnt_inc = cnt_q + 1'b1;
   assign used_o  = cnt_inc;
   assign last_o  = (cnt_inc == len_bytes(len_o));

   // The first byte clears the upper bytes, so no stale data reaches the next field.
   always_comb begin
      if (first_o) acc_next_o = {{(ACC_W-BYTE_W){1'b0}}, byte_i};
      else         acc_next_o = {acc_q[ACC_W-BYTE_W-1:0], byte_i};
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         len_q <= LEN_1B;
         acc_q <= '0;
      end else if (abort_i) begin
         cnt_q <= '0;
      end else if (take_i) begin
         acc_q <= acc_next_o;
         if (first_o) len_q <= len_first_i;
         cnt_q <= last_o ? '0 : cnt_inc;
      end
   end

   assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CNT_W'(MAX_BYTES));
endmodule

// File: rtl/disp_sign_ext.sv
module disp_sign_ext
   import disp_dec_pkg::*;
#(
   parameter int unsigned VALUE_W = 32
) (
   input  logic [BYTE_W*MAX_BYTES-1:0] raw_i,
   input  len_e                        len_i,
   input  logic                        imm_i,
   output logic [VALUE_W-1:0]          value_o
);
   localparam int unsigned N_LEN = $clog2(MAX_BYTES) + 1;
   localparam int unsigned SEL_W = $clog2(N_LEN);

   if (VALUE_W < BYTE_W * MAX_BYTES) begin : g_bad_value_w
      $error("disp_sign_ext: VALUE_W narrower than the longest field");
   end

   logic [N_LEN-1:0][VALUE_W-1:0] disp_ext;
   logic [N_LEN-1:0][VALUE_W-1:0] imm_ext;
   logic [SEL_W-1:0]              sel;

   // Field g spans BYTE_W<<g bits. A displacement loses its length prefix, an immediate keeps every bit.
   for (genvar g = 0; g < N_LEN; g++) begin : g_width
      localparam int unsigned FW = BYTE_W << g;
      localparam int unsigned DW = (g == 0) ? FW - 1 : FW - 2;
      assign disp_ext[g] = VALUE_W'($signed(raw_i[DW-1:0]));
      assign imm_ext[g]  = VALUE_W'($signed(raw_i[FW-1:0]));
   end

   always_comb begin
      case (len_i)
         LEN_1B:  sel = SEL_W'(0);
         LEN_2B:  sel = SEL_W'(1);
         default: sel = SEL_W'(2);
      endcase
      value_o = imm_i ? imm_ext[sel] : disp_ext[sel];
   end
endmodule

// File: rtl/disp_field_decoder.sv
module disp_field_decoder
   import disp_dec_pkg::*;
#(
   parameter int unsigned       VALUE_W      = 32,
   parameter logic [BYTE_W-1:0] RESERVED_PAT = 8'hE0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               pair_i,
   input  logic               imm_i,
   input  logic [1:0]         imm_size_i,
   input  logic [BYTE_W-1:0]  byte_i,
   input  logic               byte_valid_i,
   output logic               byte_ready_o,
   output logic [VALUE_W-1:0] value_o,
   output logic [2:0]         count_o,
   output logic               done_o,
   output logic               second_o,
   output logic               illegal_o
);
   if (CNT_W != 3) begin : g_bad_cnt_w
      $error("disp_field_decoder: count_o width assumes MAX_BYTES of 4");
   end

   state_e             state_q;
   mode_t              mode_q;
   logic               second_q;
   logic               take;
   len_e               det_len;
   logic               det_reserved;
   logic               col_first;
   len_e               col_len;
   logic               col_last;
   logic [CNT_W-1:0]   col_used;
   logic [BYTE_W*MAX_BYTES-1:0] col_acc;
   logic [VALUE_W-1:0] ext_value;
   logic               illegal_hit;
   logic               complete;

   logic [VALUE_W-1:0] value_q;
   logic [2:0]         count_q;
   logic               done_q;
   logic               second_out_q;
   logic               illegal_q;

   assign byte_ready_o = (state_q == ST_COLLECT);
   assign take         = byte_valid_i & byte_ready_o;

   disp_len_detect #(.RESERVED_PAT(RESERVED_PAT)) u_len (
      .lead_byte_i (byte_i),
      .imm_i       (mode_q.imm),
      .imm_len_i   (mode_q.imm_len),
      .len_o       (det_len),
      .reserved_o  (det_reserved)
   );

   disp_byte_collector u_col (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .abort_i     (illegal_hit),
      .take_i      (take),
      .byte_i      (byte_i),
      .len_first_i (det_len),
      .first_o     (col_first),
      .len_o       (col_len),
      .last_o      (col_last),
      .used_o      (col_used),
      .acc_next_o  (col_acc)
   );

   disp_sign_ext #(.VALUE_W(VALUE_W)) u_ext (
      .raw_i   (col_acc),
      .len_i   (col_len),
      .imm_i   (mode_q.imm),
      .value_o (ext_value)
   );

   assign illegal_hit = take & col_first & det_reserved;
   assign complete    = take & col_last & ~illegal_hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         mode_q   <= '{pair: 1'b0, imm: 1'b0, imm_len: LEN_1B};
         second_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q  <= ST_COLLECT;
                  mode_q   <= '{pair: pair_i & ~imm_i, imm: imm_i,
                                imm_len: size_code_to_len(imm_size_i)};
                  second_q <= 1'b0;
               end
            end
            default: begin
               if (illegal_hit) begin
                  state_q <= ST_IDLE;
               end else if (complete) begin
                  if (mode_q.pair && !second_q) second_q <= 1'b1;
                  else                          state_q  <= ST_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         value_q      <= '0;
         count_q      <= '0;
         done_q       <= 1'b0;
         second_out_q <= 1'b0;
         illegal_q    <= 1'b0;
      end else begin
         done_q    <= complete;
         illegal_q <= illegal_hit;
         if (complete) begin
            value_q      <= ext_value;
            count_q      <= col_used;
            second_out_q <= second_q;
         end
      end
   end

   assign value_o   = value_q;
   assign count_o   = count_q;
   assign done_o    = done_q;
   assign second_o  = second_out_q;
   assign illegal_o = illegal_q;

   assert_ready_after_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!byte_ready_o && start_i) |=> byte_ready_o);

   assert_count_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (count_o == 3'd1 || count_o == 3'd2 || count_o == 3'd4));

   assert_short_sext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && count_o == 3'd1 && !mode_q.imm) |->
      (value_o[VALUE_W-1:6] == '0 || value_o[VALUE_W-1:6] == '1));

   assert_idle_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !byte_ready_o) |=> !done_o);

   assert_pair_keeps_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !second_o && mode_q.pair) |-> byte_ready_o);

   assert_illegal_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> (!done_o && !byte_ready_o));
endmodule

// File: tb/disp_field_decoder_tb.sv
module disp_field_decoder_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start_i = 1'b0;
   logic        pair_i = 1'b0;
   logic        imm_i = 1'b0;
   logic [1:0]  imm_size_i = 2'b00;
   logic [7:0]  byte_i = 8'h00;
   logic        byte_valid_i = 1'b0;
   logic        byte_ready_o;
   logic [31:0] value_o;
   logic [2:0]  count_o;
   logic        done_o;
   logic        second_o;
   logic        illegal_o;

   int checks = 0;
   int errors = 0;

   always #4 clk_i = ~clk_i;

   disp_field_decoder dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pair_i(pair_i),
      .imm_i(imm_i), .imm_size_i(imm_size_i), .byte_i(byte_i),
      .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
      .value_o(value_o), .count_o(count_o), .done_o(done_o),
      .second_o(second_o), .illegal_o(illegal_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic arm(input logic p, input logic im, input logic [1:0] sz);
      start_i = 1'b1; pair_i = p; imm_i = im; imm_size_i = sz;
      @(negedge clk_i);
      start_i = 1'b0; pair_i = 1'b0; imm_i = 1'b0; imm_size_i = 2'b00;
   endtask

   task automatic push(input logic [7:0] b);
      byte_i = b; byte_valid_i = 1'b1;
      @(negedge clk_i);
      byte_valid_i = 1'b0;
   endtask

   task automatic run_field(input string req, input logic im, input logic [1:0] sz,
                            input logic [31:0] word, input int n, input logic [31:0] exp);
      arm(1'b0, im, sz);
      for (int i = 0; i < n; i++) begin
         push(word[8*(n-1-i) +: 8]);
         if (i < n - 1) chk({req, " no early done"}, 32'(done_o), 32'd0);
      end
      chk({req, " done"}, 32'(done_o), 32'd1);
      chk({req, " value"}, value_o, exp);
      chk({req, " count"}, 32'(count_o), 32'(n));
      chk({req, " no illegal"}, 32'(illegal_o), 32'd0);
      @(negedge clk_i);
      chk("R6 done one cycle", 32'(done_o), 32'd0);
      chk("R6 idle after done", 32'(byte_ready_o), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 ready low", 32'(byte_ready_o), 32'd0);
      chk("R1 done low", 32'(done_o), 32'd0);
      chk("R1 illegal low", 32'(illegal_o), 32'd0);
      push(8'h05);
      chk("R10 idle byte ignored", 32'(done_o), 32'd0);
      arm(1'b0, 1'b0, 2'b00);
      chk("R1 ready after start", 32'(byte_ready_o), 32'd1);
      push(8'h09);
      chk("R10 fresh field value", value_o, 32'h9);
      @(negedge clk_i);
   endtask

   task automatic t_lengths();
      run_field("R2 small positive", 1'b0, 2'b00, 32'h05, 1, 32'h5);
      run_field("R5 R2 all ones", 1'b0, 2'b00, 32'h7F, 1, 32'hFFFF_FFFF);
      run_field("R5 R2 min", 1'b0, 2'b00, 32'h40, 1, 32'hFFFF_FFC0);
      run_field("R3 positive", 1'b0, 2'b00, 32'h8123, 2, 32'h123);
      run_field("R5 R3 minus one", 1'b0, 2'b00, 32'hBFFF, 2, 32'hFFFF_FFFF);
      run_field("R5 R3 min", 1'b0, 2'b00, 32'hA000, 2, 32'hFFFF_E000);
      run_field("R4 positive", 1'b0, 2'b00, 32'hC102_0304, 4, 32'h0102_0304);
      run_field("R5 R4 negative", 1'b0, 2'b00, 32'hF000_0000, 4, 32'hF000_0000);
      run_field("R4 max positive", 1'b0, 2'b00, 32'hDFFF_FFFF, 4, 32'h1FFF_FFFF);
   endtask

   task automatic t_stall();
      arm(1'b0, 1'b0, 2'b00);
      push(8'h81);
      repeat (3) @(negedge clk_i);
      chk("R11 stall keeps ready", 32'(byte_ready_o), 32'd1);
      chk("R11 stall no done", 32'(done_o), 32'd0);
      push(8'h23);
      chk("R11 stalled value", value_o, 32'h123);
      chk("R11 stalled count", 32'(count_o), 32'd2);
      @(negedge clk_i);
   endtask

   task automatic t_pair();
      arm(1'b1, 1'b0, 2'b00);
      push(8'h05);
      chk("R7 first done", 32'(done_o), 32'd1);
      chk("R7 first value", value_o, 32'h5);
      chk("R7 first not second", 32'(second_o), 32'd0);
      chk("R7 ready kept", 32'(byte_ready_o), 32'd1);
      push(8'h81);
      chk("R7 second in progress", 32'(done_o), 32'd0);
      push(8'h00);
      chk("R7 second value", value_o, 32'h100);
      chk("R7 second flag", 32'(second_o), 32'd1);
      chk("R7 second count", 32'(count_o), 32'd2);
      @(negedge clk_i);
      chk("R7 idle after pair", 32'(byte_ready_o), 32'd0);
      // Back-to-back single-byte pair: two strobes in consecutive cycles.
      arm(1'b1, 1'b0, 2'b00);
      push(8'h7F);
      chk("R7 b2b first value", value_o, 32'hFFFF_FFFF);
      push(8'h02);
      chk("R7 b2b second done", 32'(done_o), 32'd1);
      chk("R7 b2b second value", value_o, 32'h2);
      chk("R7 b2b second flag", 32'(second_o), 32'd1);
      @(negedge clk_i);
      chk("R7 b2b done drops", 32'(done_o), 32'd0);
   endtask

   task automatic t_imm();
      run_field("R8 imm byte", 1'b1, 2'b00, 32'h80, 1, 32'hFFFF_FF80);
      run_field("R8 imm word", 1'b1, 2'b01, 32'h1234, 2, 32'h1234);
      run_field("R8 imm long E0", 1'b1, 2'b10, 32'hE000_0001, 4, 32'hE000_0001);
      run_field("R8 imm code 11", 1'b1, 2'b11, 32'h7FFF_FFFF, 4, 32'h7FFF_FFFF);
      arm(1'b1, 1'b1, 2'b00);
      push(8'h12);
      chk("R8 imm pair ignored value", value_o, 32'h12);
      @(negedge clk_i);
      chk("R8 imm pair ignored idle", 32'(byte_ready_o), 32'd0);
   endtask

   task automatic t_illegal();
      arm(1'b0, 1'b0, 2'b00);
      push(8'hE0);
      chk("R9 illegal flag", 32'(illegal_o), 32'd1);
      chk("R9 no done", 32'(done_o), 32'd0);
      chk("R9 idle", 32'(byte_ready_o), 32'd0);
      @(negedge clk_i);
      chk("R9 flag one cycle", 32'(illegal_o), 32'd0);
      arm(1'b1, 1'b0, 2'b00);
      push(8'h10);
      chk("R9 pair first value", value_o, 32'h10);
      push(8'hE0);
      chk("R9 pair illegal", 32'(illegal_o), 32'd1);
      chk("R9 pair abandoned", 32'(byte_ready_o), 32'd0);
      push(8'h01);
      chk("R9 no late done", 32'(done_o), 32'd0);
      chk("R9 value held", value_o, 32'h10);
   endtask

   task automatic t_busy_start();
      arm(1'b0, 1'b0, 2'b00);
      push(8'h81);
      arm(1'b1, 1'b1, 2'b00);
      push(8'h00);
      chk("R10 busy start value", value_o, 32'h100);
      chk("R10 busy start count", 32'(count_o), 32'd2);
      @(negedge clk_i);
      chk("R10 busy start no pair", 32'(byte_ready_o), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_lengths();
      t_stall();
      t_pair();
      t_imm();
      t_illegal();
      t_busy_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule